// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM device from power-on to an operational state. After reset it stays quiet with clock-enable low. A start pulse launches a fixed command script on the memory command bus, which carries the clock enable, the four command strobes, the bank address and the row address. The script is a stabilisation wait, precharges, the four mode-register writes, two refreshes, the DLL reset and release, and OCD calibration entry and exit. Each command is separated from the next by a timing gap that depends on the kind of command. When the device is ready, `done` rises and stays high, and the surrounding controller may then begin its own refresh scheduling.

The mode-register payloads, the address geometry and the clock rate are static inputs. The clock rate is given as clock cycles per microsecond. From the geometry the block also computes the system-address bit position at which the bank field starts, so that the controller can place mode-register accesses correctly.

States: `ST_IDLE` (start moves to `ST_NOP_A`), `ST_NOP_A`, `ST_NOP_B`, `ST_PRE_A`, `ST_EMR2`, `ST_EMR3`, `ST_EMR1_EN`, `ST_MRS_DLLRST`, `ST_PRE_B`, `ST_REF_A`, `ST_REF_B`, `ST_MRS_RUN`, `ST_EMR1_OCD`, `ST_EMR1_EXIT`. Each of these command states lasts one cycle, loads the gap timer and moves to `ST_GAP`. `ST_GAP` returns to the stored successor state when the timer reaches its last cycle. The successor of `ST_EMR1_EXIT` is `ST_NORMAL`, which moves to `ST_DONE` once the DLL lock counter is empty. `ST_DONE` is held until reset.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: From reset until start is sampled high, `cke` is 0, `done` is 0 and the bus shows NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111); no other command appears.
- R2: The cycle after start is sampled, the bus shows a NOP with `cke` still 0. `cke` rises together with a second NOP exactly S cycles after that first NOP, where S = 200 × `cyc_per_us` (or 2 if that product is below 2). `cke` then stays 1 until reset.
- R3: After the second NOP exactly eleven non-NOP commands are issued, in this order: PRE, EMRS2, EMRS3, EMRS1, MRS, PRE, REF, REF, MRS, EMRS1, EMRS1. The encodings are PRE = 4'b0010, REF = 4'b0001 and MRS/EMRS = 4'b0000.
- R4: Precharge drives only address bit 10 high, with bank 0. Refresh drives bank 0 and address 0. EMRS2 drives bank 2 with `emr2_val`. EMRS3 drives bank 3 with address 0. Plain MRS drives bank 0.
- R5: The first MRS drives `mr_val` with address bit 8 (DLL reset) forced to 1. The second MRS drives `mr_val` with bit 8 forced to 0.
- R6: The three EMRS1 writes drive bank 1 and `emr1_val` with bit 0 (DLL disable) forced to 0. Address bits 9:7 (OCD field) are 000, then 111, then 000.
- R7: The first precharge comes 8 cycles (T_CKE) after the second NOP. Each later command comes exactly T_RP = 5 cycles after a precharge, T_MRD = 3 cycles after a mode-register write, or T_RFC = 20 cycles after a refresh. Every command lasts one cycle, and NOP fills the cycles between commands.
- R8: Exactly two refresh commands are issued during the sequence.
- R9: `done` rises in cycle max(N, M + 200) + 1, where N is T_MRD cycles after the last EMRS1 and M is the cycle of the DLL-reset MRS. `done` then stays 1 until reset, and no further command is issued.
- R10: A start pulse received while the sequence runs, or after `done`, changes neither the command trace nor its timing.
- R11: `bank_pos` equals `col_cfg` + 9, plus `row_cfg` + 11 when `seq_decode` is 1, plus 1 when `half_width` is 1 or 2 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts the sequence from idle |
| cyc_per_us | input | 10 | Clock cycles per microsecond |
| col_cfg | input | 2 | Column-bit count code |
| row_cfg | input | 2 | Row-bit count code |
| seq_decode | input | 1 | 1 = sequential bank decode, 0 = interleaved |
| half_width | input | 1 | 1 = half-width data bus |
| mr_val | input | 14 | Mode register payload |
| emr1_val | input | 14 | Extended mode register 1 payload |
| emr2_val | input | 14 | Extended mode register 2 payload |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | 14 | Row address lines |
| bank_pos | output | 6 | Bank field bit position in the system address |
| done | output | 1 | Initialization complete |

## Verification
All of the block's results are due at cycles that can be computed from the moment `start` is sampled. The first NOP follows one cycle later. The `cke` rise comes S cycles after that. Each command's cycle is its predecessor's cycle plus the gap for the predecessor's kind, and `done` comes one cycle after the later of the normal-mode entry and the DLL lock window. `bank_pos` is combinational and is checked while reset is held. The bench stamps each observed command, the `cke` rise and the `done` rise with a cycle count taken at the falling edge. After the run it compares every stamp and payload with the value its own functions compute, so no check depends on when it happens to look.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_NOP_A,
        ST_NOP_B,
        ST_PRE_A,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1_EN,
        ST_MRS_DLLRST,
        ST_PRE_B,
        ST_REF_A,
        ST_REF_B,
        ST_MRS_RUN,
        ST_EMR1_OCD,
        ST_EMR1_EXIT,
        ST_GAP,
        ST_NORMAL,
        ST_DONE
    } seq_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

    // address bit positions that the memory device decodes
    localparam int A_ALLBANK = 10;
    localparam int A_DLLRST  = 8;
    localparam int A_OCD_LSB = 7;
    localparam int A_OCD_W   = 3;
    localparam int A_DLLOFF  = 0;

    // bank selector values for the mode register targets
    localparam int BA_SEL_MR   = 0;
    localparam int BA_SEL_EMR1 = 1;
    localparam int BA_SEL_EMR2 = 2;
    localparam int BA_SEL_EMR3 = 3;

    function automatic int at_least_two(input int v);
        return (v < 2) ? 2 : v;
    endfunction

endpackage

// File: rtl/ddr2_bank_pos.sv
module ddr2_bank_pos #(
    parameter int CFG_W = 2,
    parameter int BP_W  = 6
) (
    input  logic [CFG_W-1:0] col_cfg,
    input  logic [CFG_W-1:0] row_cfg,
    input  logic             seq_decode,
    input  logic             half_width,
    output logic [BP_W-1:0]  bank_pos
);
    localparam int COL_BASE = 9;
    localparam int ROW_BASE = 11;

    logic [BP_W-1:0] col_part;
    logic [BP_W-1:0] row_part;
    logic [BP_W-1:0] bus_part;

    always_comb begin
        col_part = BP_W'(col_cfg) + BP_W'(COL_BASE);
        row_part = seq_decode ? (BP_W'(row_cfg) + BP_W'(ROW_BASE)) : '0;
        bus_part = half_width ? BP_W'(1) : BP_W'(2);
        bank_pos = col_part + row_part + bus_part;
    end

endmodule

// File: rtl/ddr2_gap_timer.sv
module ddr2_gap_timer #(
    parameter int TMR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             last
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == TMR_W'(1));

endmodule

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3
) (
    input  seq_state_e        state,
    input  logic [ADDR_W-1:0] mr_val,
    input  logic [ADDR_W-1:0] emr1_val,
    input  logic [ADDR_W-1:0] emr2_val,
    output logic [3:0]        cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ALLBANK_M = ADDR_W'(1) << A_ALLBANK;
    localparam logic [ADDR_W-1:0] DLLRST_M  = ADDR_W'(1) << A_DLLRST;
    localparam logic [ADDR_W-1:0] DLLOFF_M  = ADDR_W'(1) << A_DLLOFF;
    localparam logic [ADDR_W-1:0] OCD_M     = ADDR_W'((1 << A_OCD_W) - 1) << A_OCD_LSB;

    logic [ADDR_W-1:0] emr1_base;
    assign emr1_base = emr1_val & ~(OCD_M | DLLOFF_M);

    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        unique case (state)
            ST_PRE_A, ST_PRE_B: begin
                cmd  = CMD_PRE;
                addr = ALLBANK_M;
            end
            ST_REF_A, ST_REF_B: begin
                cmd = CMD_REF;
            end
            ST_EMR2: begin
                cmd  = CMD_MRS;
                ba   = BA_W'(BA_SEL_EMR2);
                addr = emr2_val;
            end
            ST_EMR3: begin
                cmd = CMD_MRS;
                ba  = BA_W'(BA_SEL_EMR3);
            end
            ST_EMR1_EN, ST_EMR1_EXIT: begin
                cmd  = CMD_MRS;
                ba   = BA_W'(BA_SEL_EMR1);
                addr = emr1_base;
            end
            ST_EMR1_OCD: begin
                cmd  = CMD_MRS;
                ba   = BA_W'(BA_SEL_EMR1);
                addr = emr1_base | OCD_M;
            end
            ST_MRS_DLLRST: begin
                cmd  = CMD_MRS;
                ba   = BA_W'(BA_SEL_MR);
                addr = mr_val | DLLRST_M;
            end
            ST_MRS_RUN: begin
                cmd  = CMD_MRS;
                ba   = BA_W'(BA_SEL_MR);
                addr = mr_val & ~DLLRST_M;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int BA_W    = 3,
    parameter int CFG_W   = 2,
    parameter int BP_W    = 6,
    parameter int CPU_W   = 10,
    parameter int TMR_W   = 20,
    parameter int STAB_US = 200,
    parameter int T_CKE   = 8,
    parameter int T_RP    = 5,
    parameter int T_MRD   = 3,
    parameter int T_RFC   = 20,
    parameter int DLL_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CPU_W-1:0]  cyc_per_us,
    input  logic [CFG_W-1:0]  col_cfg,
    input  logic [CFG_W-1:0]  row_cfg,
    input  logic              seq_decode,
    input  logic              half_width,
    input  logic [ADDR_W-1:0] mr_val,
    input  logic [ADDR_W-1:0] emr1_val,
    input  logic [ADDR_W-1:0] emr2_val,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [BP_W-1:0]   bank_pos,
    output logic              done
);
    localparam int CKE_C = at_least_two(T_CKE);
    localparam int RP_C  = at_least_two(T_RP);
    localparam int MRD_C = at_least_two(T_MRD);
    localparam int RFC_C = at_least_two(T_RFC);
    localparam int DLL_W = $clog2(DLL_CYC + 1);

    localparam logic [TMR_W-1:0] CKE_LD = TMR_W'(CKE_C - 1);
    localparam logic [TMR_W-1:0] RP_LD  = TMR_W'(RP_C - 1);
    localparam logic [TMR_W-1:0] MRD_LD = TMR_W'(MRD_C - 1);
    localparam logic [TMR_W-1:0] RFC_LD = TMR_W'(RFC_C - 1);

    seq_state_e       state_q, state_d;
    seq_state_e       ret_q, ret_d;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_last;
    logic [TMR_W-1:0] stab_raw;
    logic [TMR_W-1:0] stab_cyc;
    logic [DLL_W-1:0] dll_cnt_q;
    logic             cke_q;
    logic             done_q;
    logic [3:0]       cmd;

    // stabilisation wait length in cycles
    always_comb begin
        stab_raw = TMR_W'(cyc_per_us) * TMR_W'(STAB_US);
        stab_cyc = (stab_raw < TMR_W'(2)) ? TMR_W'(2) : stab_raw;
    end

    ddr2_bank_pos #(
        .CFG_W (CFG_W),
        .BP_W  (BP_W)
    ) u_bank_pos (
        .col_cfg    (col_cfg),
        .row_cfg    (row_cfg),
        .seq_decode (seq_decode),
        .half_width (half_width),
        .bank_pos   (bank_pos)
    );

    ddr2_gap_timer #(
        .TMR_W (TMR_W)
    ) u_gap_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    ddr2_cmd_decode #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_cmd_decode (
        .state    (state_q),
        .mr_val   (mr_val),
        .emr1_val (emr1_val),
        .emr2_val (emr2_val),
        .cmd      (cmd),
        .ba       (ba),
        .addr     (addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_NOP_A;
            end
            ST_NOP_A: begin
                state_d = ST_GAP; ret_d = ST_NOP_B;
                tmr_load = 1'b1; tmr_val = stab_cyc - 1'b1;
            end
            ST_NOP_B: begin
                state_d = ST_GAP; ret_d = ST_PRE_A;
                tmr_load = 1'b1; tmr_val = CKE_LD;
            end
            ST_PRE_A: begin
                state_d = ST_GAP; ret_d = ST_EMR2;
                tmr_load = 1'b1; tmr_val = RP_LD;
            end
            ST_EMR2: begin
                state_d = ST_GAP; ret_d = ST_EMR3;
                tmr_load = 1'b1; tmr_val = MRD_LD;
            end
            ST_EMR3: begin
                state_d = ST_GAP; ret_d = ST_EMR1_EN;
                tmr_load = 1'b1; tmr_val = MRD_LD;
            end
            ST_EMR1_EN: begin
                state_d = ST_GAP; ret_d = ST_MRS_DLLRST;
                tmr_load = 1'b1; tmr_val = MRD_LD;
            end
            ST_MRS_DLLRST: begin
                state_d = ST_GAP; ret_d = ST_PRE_B;
                tmr_load = 1'b1; tmr_val = MRD_LD;
            end
            ST_PRE_B: begin
                state_d = ST_GAP; ret_d = ST_REF_A;
                tmr_load = 1'b1; tmr_val = RP_LD;
            end
            ST_REF_A: begin
                state_d = ST_GAP; ret_d = ST_REF_B;
                tmr_load = 1'b1; tmr_val = RFC_LD;
            end
            ST_REF_B: begin
                state_d = ST_GAP; ret_d = ST_MRS_RUN;
                tmr_load = 1'b1; tmr_val = RFC_LD;
            end
            ST_MRS_RUN: begin
                state_d = ST_GAP; ret_d = ST_EMR1_OCD;
                tmr_load = 1'b1; tmr_val = MRD_LD;
            end
            ST_EMR1_OCD: begin
                state_d = ST_GAP; ret_d = ST_EMR1_EXIT;
                tmr_load = 1'b1; tmr_val = MRD_LD;
            end
            ST_EMR1_EXIT: begin
                state_d = ST_GAP; ret_d = ST_NORMAL;
                tmr_load = 1'b1; tmr_val = MRD_LD;
            end
            ST_GAP: begin
                if (tmr_last) state_d = ret_q;
            end
            ST_NORMAL: begin
                if (dll_cnt_q == '0) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // DLL lock window counter, started by the DLL-reset MRS
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_cnt_q <= '0;
        end else if (state_q == ST_MRS_DLLRST) begin
            dll_cnt_q <= DLL_W'(DLL_CYC - 1);
        end else if (dll_cnt_q != '0) begin
            dll_cnt_q <= dll_cnt_q - 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cke_q  <= cke_q  | (state_d == ST_NOP_B);
            done_q <= done_q | (state_d == ST_DONE);
        end
    end

    assign cke  = cke_q;
    assign done = done_q;
    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R9
    done_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dll_cnt_q == '0));

    // R7
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!cke && !done && cmd == CMD_NOP));

    // R4
    prech_allbank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (addr[A_ALLBANK] && ba == '0));

    // R2
    cke_before_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> cke);

endmodule

// File: tb/test_ddr2_pwrup_seq.sv
module test_ddr2_pwrup_seq;

    localparam int T_CKE = 8;
    localparam int T_RP  = 5;
    localparam int T_MRD = 3;
    localparam int T_RFC = 20;
    localparam int DLL   = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  cyc_per_us = 10'd1;
    logic [1:0]  col_cfg = '0;
    logic [1:0]  row_cfg = '0;
    logic        seq_decode = 1'b0;
    logic        half_width = 1'b0;
    logic [13:0] mr_val = '0;
    logic [13:0] emr1_val = '0;
    logic [13:0] emr2_val = '0;
    logic        cke, cs_n, ras_n, cas_n, we_n, done;
    logic [2:0]  ba;
    logic [13:0] addr;
    logic [5:0]  bank_pos;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    logic [20:0] got_cmd [0:31];
    int          got_cyc [0:31];
    int          n_got = 0;
    int          cke_cyc = -1;
    int          done_cyc = -1;
    bit          cke_drop = 0;
    bit          done_drop = 0;

    ddr2_pwrup_seq #(
        .T_CKE (T_CKE), .T_RP (T_RP), .T_MRD (T_MRD),
        .T_RFC (T_RFC), .DLL_CYC (DLL)
    ) i_ddr2_pwrup_seq (
        .clk (clk), .rst_n (rst_n), .start (start), .cyc_per_us (cyc_per_us),
        .col_cfg (col_cfg), .row_cfg (row_cfg), .seq_decode (seq_decode),
        .half_width (half_width), .mr_val (mr_val), .emr1_val (emr1_val),
        .emr2_val (emr2_val), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr),
        .bank_pos (bank_pos), .done (done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cke && cke_cyc < 0) cke_cyc = cyc;
            if (!cke && cke_cyc >= 0) cke_drop = 1;
            if (done && done_cyc < 0) done_cyc = cyc;
            if (!done && done_cyc >= 0) done_drop = 1;
            if (!cs_n && !(ras_n && cas_n && we_n)) begin
                if (n_got < 32) begin
                    got_cmd[n_got] = {cs_n, ras_n, cas_n, we_n, ba, addr};
                    got_cyc[n_got] = cyc;
                end
                n_got++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_bank_pos(input int c, input int r, input bit sq, input bit hw);
        return c + 9 + (sq ? r + 11 : 0) + (hw ? 1 : 2);
    endfunction

    function automatic logic [20:0] exp_cmd(input int i, input logic [13:0] m,
                                            input logic [13:0] e1, input logic [13:0] e2);
        logic [13:0] e1b;
        e1b = e1 & ~14'h0381;
        case (i)
            0, 5:  return {4'b0010, 3'd0, 14'h0400};
            1:     return {4'b0000, 3'd2, e2};
            2:     return {4'b0000, 3'd3, 14'h0000};
            3, 10: return {4'b0000, 3'd1, e1b};
            4:     return {4'b0000, 3'd0, m | 14'h0100};
            6, 7:  return {4'b0001, 3'd0, 14'h0000};
            8:     return {4'b0000, 3'd0, m & ~14'h0100};
            default: return {4'b0000, 3'd1, e1b | 14'h0380};
        endcase
    endfunction

    function automatic int exp_gap(input int i);
        case (i)
            0, 5:  return T_RP;
            6, 7:  return T_RFC;
            default: return T_MRD;
        endcase
    endfunction

    function automatic string cmd_tag(input int i);
        case (i)
            4, 8:      return "R5";
            3, 9, 10:  return "R6";
            default:   return "R4";
        endcase
    endfunction

    task automatic run_case(input logic [1:0] c, input logic [1:0] r, input bit sq,
                            input bit hw, input int cpu, input logic [13:0] m,
                            input logic [13:0] e1, input logic [13:0] e2, input bit noise);
        int t0, stab, waited, nrm, dexp, nref;
        int ec [0:10];
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0;
        col_cfg = c; row_cfg = r; seq_decode = sq; half_width = hw;
        cyc_per_us = 10'(cpu); mr_val = m; emr1_val = e1; emr2_val = e2;
        repeat (3) @(negedge clk);
        chk("R1", "cke/done/bus in reset", {cke, done, cs_n, ras_n, cas_n, we_n}, 6'b000111);
        chk("R11", "bank_pos", bank_pos, exp_bank_pos(c, r, sq, hw));
        n_got = 0; cke_cyc = -1; done_cyc = -1; cke_drop = 0; done_drop = 0;
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1", "idle before start", {n_got[4:0], cke, done}, 7'd0);
        start = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (done_cyc < 0 && waited < 5000) begin
            @(negedge clk); #1;
            waited++;
            start = (noise && ($urandom % 4 == 0));
        end
        if (done_cyc < 0) begin
            n_chk++; n_err++;
            $display("FAIL R9 done never rose: actual 0 expected 1");
        end
        repeat (40) begin
            @(negedge clk); #1;
            start = (noise && ($urandom % 3 == 0));
        end
        start = 1'b0;
        stab = (200 * cpu < 2) ? 2 : 200 * cpu;
        chk("R2", "cke rise cycle", cke_cyc, t0 + stab);
        chk("R2", "cke held", cke_drop, 0);
        chk(noise ? "R10" : "R3", "command count", n_got, 11);
        ec[0] = t0 + stab + T_CKE;
        for (int i = 0; i < 10; i++) ec[i+1] = ec[i] + exp_gap(i);
        nref = 0;
        for (int i = 0; i < 11 && i < n_got; i++) begin
            chk(cmd_tag(i), $sformatf("R3 command %0d", i), got_cmd[i], exp_cmd(i, m, e1, e2));
            chk("R7", $sformatf("command %0d cycle", i), got_cyc[i], ec[i]);
            if (got_cmd[i][20:17] == 4'b0001) nref++;
        end
        chk("R8", "refresh count", nref, 2);
        nrm = ec[10] + T_MRD;
        dexp = ((nrm > ec[4] + DLL) ? nrm : ec[4] + DLL) + 1;
        chk(noise ? "R10" : "R9", "done rise cycle", done_cyc, dexp);
        chk("R9", "done held", done_drop, 0);
    endtask

    initial begin
        void'($urandom(32'h2C0DE));
        run_case(2'd3, 2'd3, 1'b1, 1'b0, 1, 14'h3FFF, 14'h3FFF, 14'h0000, 1'b0);
        run_case(2'd0, 2'd0, 1'b0, 1'b1, 0, 14'h0000, 14'h0000, 14'h3FFF, 1'b1);
        for (int k = 0; k < 4; k++) begin
            run_case(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                     1 + int'($urandom % 3), 14'($urandom), 14'($urandom),
                     14'($urandom), (k % 2) == 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule